// File: doc/BRIEF.md
# Twenty-Channel Camera Line Interleaver

This block takes pixel streams from a set of synchronized camera channels, twenty by default, and turns them into one time-multiplexed stream for a frame-memory writer. All cameras share one line-valid and one pixel-valid strobe. On each pixel-valid cycle the block receives one 16-bit pixel from every channel at once, and it writes the whole set into one row of a line store. The store holds two line slots. One slot fills while the other one drains.

When line-valid falls, the slot just filled is handed across to a faster system clock. The readout side then sends that line out channel by channel, one beat per system clock. Channel 0 comes first with pixels 0 to the last, then channel 1, and so on. The camera side meanwhile fills the other slot. Each beat carries the channel index, the pixel index, the pixel value and a flag that marks the last pixel of a channel's line.

The system clock must be fast enough that one full readout of NUM_CH × LINE_W cycles fits inside one camera line period. If a new line completes before the readout has ended, a sticky overrun flag is raised and the readout restarts on the newer line.

Top module: `cam_line_mux`

## Requirements
- R1: After reset, outValid, outLast and overrun are all low.
- R2: While lineValid is high, each camClk cycle with pixValid high captures one pixel for every channel at the next pixel position of the current line, starting at position 0. Channel c is taken from pixData bits [c*PIX_W +: PIX_W].
- R3: Pixels presented after LINE_W pixels have been captured in the same line are ignored. They change no value that is later read out.
- R4: A falling edge of lineValid ends the line. The readout of exactly that line starts on the system clock a few cycles later, and the next line is captured into the other slot.
- R5: A readout is NUM_CH × LINE_W consecutive sysClk beats with no gap. Channels go in order 0 to NUM_CH-1, and within each channel pixels go in order 0 to LINE_W-1.
- R6: On every beat, outData equals the pixel captured for channel outChan at position outPix of the line being read out.
- R7: outLast is high exactly on beats whose outPix equals LINE_W-1.
- R8: Outside a readout, outValid and outLast stay low.
- R9: If a line ends while a readout is still running, overrun goes high and stays high until reset. The readout then restarts at channel 0, pixel 0 of the newer line. Without such an event, overrun stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| camClk | input | 1 | Camera pixel clock |
| camRstN | input | 1 | Active-low reset, camera domain |
| lineValid | input | 1 | Shared line-active strobe from all cameras |
| pixValid | input | 1 | Shared pixel strobe from all cameras |
| pixData | input | NUM_CH*PIX_W | One pixel per channel, channel c at bits c*PIX_W |
| sysClk | input | 1 | System clock for the readout side |
| sysRstN | input | 1 | Active-low reset, system domain |
| outValid | output | 1 | Output beat valid |
| outChan | output | $clog2(NUM_CH) | Channel index of the beat |
| outPix | output | $clog2(LINE_W) | Pixel index of the beat |
| outData | output | PIX_W | Pixel value |
| outLast | output | 1 | Last pixel of the channel's line |
| overrun | output | 1 | Sticky: a line ended during a readout |

## Verification
The hardest case to reach is a line that ends while the previous readout is still running. This only happens when camera lines arrive faster than the readout can drain them, and it breaks an output burst in the middle. The stimulus reaches it by sending two lines with only one blanking cycle between them, after a run of well-spaced lines. The checker then expects a jump back to channel 0, pixel 0 carrying the newer line's data, with overrun set at that moment. Pixel-valid gaps inside lines and a line with surplus pixels cover capture positions that a plain back-to-back stream never reaches.

// File: rtl/clm_pkg.sv
package clm_pkg;
  localparam int IDX_W = 16;

  typedef struct packed {
    logic             wrEn;
    logic             wrBank;
    logic [IDX_W-1:0] wrPix;
  } camStrobe_t;

  typedef struct packed {
    logic             rdEn;
    logic             rdBank;
    logic [IDX_W-1:0] rdPix;
    logic [IDX_W-1:0] rdChan;
    logic             rdLast;
  } sysStrobe_t;
endpackage

// File: rtl/clm_ctrl.sv
module clm_ctrl
  import clm_pkg::*;
#(
  parameter int NUM_CH = 20,
  parameter int LINE_W = 352
) (
  input  logic       camClk,
  input  logic       camRstN,
  input  logic       lineValid,
  input  logic       pixValid,
  input  logic       sysClk,
  input  logic       sysRstN,
  output camStrobe_t camStb,
  output sysStrobe_t sysStb,
  output logic       overrun
);
  localparam int CNT_W  = $clog2(LINE_W + 1);
  localparam int PIX_AW = $clog2(LINE_W);
  localparam int CH_W   = $clog2(NUM_CH);

  // camera side: position counter, slot select and swap toggle
  logic [CNT_W-1:0] wrCnt;
  logic             wrBank, lvPrev, swapTgl, wrEn;

  assign wrEn = lineValid && pixValid && (wrCnt < CNT_W'(LINE_W));

  always_ff @(posedge camClk or negedge camRstN) begin
    if (!camRstN) begin
      wrCnt   <= '0;
      wrBank  <= 1'b0;
      lvPrev  <= 1'b0;
      swapTgl <= 1'b0;
    end else begin
      lvPrev <= lineValid;
      if (lvPrev && !lineValid) begin
        wrCnt   <= '0;
        wrBank  <= ~wrBank;
        swapTgl <= ~swapTgl;
      end else if (wrEn) begin
        wrCnt <= wrCnt + 1'b1;
      end
    end
  end

  assign camStb.wrEn   = wrEn;
  assign camStb.wrBank = wrBank;
  assign camStb.wrPix  = IDX_W'(wrCnt);

  // system side: toggle synchronizer and readout sequencer
  logic             sync1, sync2, sync3, evt;
  logic             busy, rdBank, nextRd;
  logic [PIX_AW-1:0] px;
  logic [CH_W-1:0]   ch;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= swapTgl;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign evt = sync2 ^ sync3;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      busy    <= 1'b0;
      px      <= '0;
      ch      <= '0;
      rdBank  <= 1'b0;
      nextRd  <= 1'b0;
      overrun <= 1'b0;
    end else if (evt) begin
      if (busy) overrun <= 1'b1;
      busy   <= 1'b1;
      px     <= '0;
      ch     <= '0;
      rdBank <= nextRd;
      nextRd <= ~nextRd;
    end else if (busy) begin
      if (px == PIX_AW'(LINE_W - 1)) begin
        px <= '0;
        if (ch == CH_W'(NUM_CH - 1)) begin
          busy <= 1'b0;
          ch   <= '0;
        end else begin
          ch <= ch + 1'b1;
        end
      end else begin
        px <= px + 1'b1;
      end
    end
  end

  assign sysStb.rdEn   = busy;
  assign sysStb.rdBank = rdBank;
  assign sysStb.rdPix  = IDX_W'(px);
  assign sysStb.rdChan = IDX_W'(ch);
  assign sysStb.rdLast = busy && (px == PIX_AW'(LINE_W - 1));

  // R9: overrun is sticky until reset
  a_r9_sticky: assert property (@(posedge sysClk) disable iff (!sysRstN)
    overrun |=> overrun);

  // R4: a swap event always moves the readout to the other slot
  a_r4_slot_swap: assert property (@(posedge sysClk) disable iff (!sysRstN)
    evt |=> (busy && rdBank != nextRd));
endmodule

// File: rtl/clm_datapath.sv
module clm_datapath
  import clm_pkg::*;
#(
  parameter int NUM_CH = 20,
  parameter int PIX_W  = 16,
  parameter int LINE_W = 352
) (
  input  logic                    camClk,
  input  logic                    sysClk,
  input  logic                    sysRstN,
  input  logic [NUM_CH*PIX_W-1:0] pixData,
  input  camStrobe_t              camStb,
  input  sysStrobe_t              sysStb,
  output logic                    outValid,
  output logic [$clog2(NUM_CH)-1:0] outChan,
  output logic [$clog2(LINE_W)-1:0] outPix,
  output logic [PIX_W-1:0]        outData,
  output logic                    outLast
);
  localparam int DEPTH  = 2 * LINE_W;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PIX_AW = $clog2(LINE_W);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ROW_W  = NUM_CH * PIX_W;

  logic [ROW_W-1:0] lineStore [DEPTH];
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [ROW_W-1:0]  rdRow;
  logic [CH_W-1:0]   rdCh;

  assign wrAddr = ADDR_W'(camStb.wrPix) + (camStb.wrBank ? ADDR_W'(LINE_W) : '0);
  assign rdAddr = ADDR_W'(sysStb.rdPix) + (sysStb.rdBank ? ADDR_W'(LINE_W) : '0);
  assign rdCh   = CH_W'(sysStb.rdChan);

  always_ff @(posedge camClk) begin
    if (camStb.wrEn) lineStore[wrAddr] <= pixData;
  end

  assign rdRow = lineStore[rdAddr];

  always_ff @(posedge sysClk) begin
    outData <= rdRow[int'(rdCh) * PIX_W +: PIX_W];
    outChan <= rdCh;
    outPix  <= PIX_AW'(sysStb.rdPix);
  end

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      outValid <= sysStb.rdEn;
      outLast  <= sysStb.rdLast;
    end
  end

  // R7: last flag only on the final pixel of a channel line
  a_r7_last_pos: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (outValid && outLast) |-> (outPix == PIX_AW'(LINE_W - 1)));

  // R8: nothing flagged while idle
  a_r8_idle_quiet: assert property (@(posedge sysClk) disable iff (!sysRstN)
    !outValid |-> !outLast);
endmodule

// File: rtl/cam_line_mux.sv
module cam_line_mux
  import clm_pkg::*;
#(
  parameter int NUM_CH = 20,
  parameter int PIX_W  = 16,
  parameter int LINE_W = 352,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PIX_AW = $clog2(LINE_W)
) (
  input  logic                    camClk,
  input  logic                    camRstN,
  input  logic                    lineValid,
  input  logic                    pixValid,
  input  logic [NUM_CH*PIX_W-1:0] pixData,
  input  logic                    sysClk,
  input  logic                    sysRstN,
  output logic                    outValid,
  output logic [CH_W-1:0]         outChan,
  output logic [PIX_AW-1:0]       outPix,
  output logic [PIX_W-1:0]        outData,
  output logic                    outLast,
  output logic                    overrun
);
  camStrobe_t camStb;
  sysStrobe_t sysStb;

  clm_ctrl #(.NUM_CH(NUM_CH), .LINE_W(LINE_W)) uCtrl (
    .camClk(camClk), .camRstN(camRstN), .lineValid(lineValid), .pixValid(pixValid),
    .sysClk(sysClk), .sysRstN(sysRstN), .camStb(camStb), .sysStb(sysStb),
    .overrun(overrun)
  );

  clm_datapath #(.NUM_CH(NUM_CH), .PIX_W(PIX_W), .LINE_W(LINE_W)) uData (
    .camClk(camClk), .sysClk(sysClk), .sysRstN(sysRstN), .pixData(pixData),
    .camStb(camStb), .sysStb(sysStb), .outValid(outValid), .outChan(outChan),
    .outPix(outPix), .outData(outData), .outLast(outLast)
  );

  // R5: within a burst each beat steps one pixel, or restarts at the origin
  a_r5_step: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (outValid && !outLast) |=> (outValid &&
      ((outChan == $past(outChan) && outPix == $past(outPix) + 1'b1) ||
       (outChan == '0 && outPix == '0))));

  // R5: a channel's last beat is followed by the next channel or the end of the burst
  a_r5_chan_adv: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (outValid && outLast && outChan != CH_W'(NUM_CH - 1)) |=>
      (outValid && outPix == '0 &&
       (outChan == $past(outChan) + 1'b1 || outChan == '0)));
endmodule

// File: tb/sim_cam_line_mux.sv
`timescale 1ns/1ps
module sim_cam_line_mux;
  localparam int NCH = 20;
  localparam int PW  = 16;
  localparam int LW  = 16;
  localparam int NL  = 32;

  logic camClk = 0, sysClk = 0, camRstN = 0, sysRstN = 0;
  logic lineValid = 0, pixValid = 0;
  logic [NCH*PW-1:0] pixData = '0;
  logic outValid, outLast, overrun;
  logic [$clog2(NCH)-1:0] outChan;
  logic [$clog2(LW)-1:0]  outPix;
  logic [PW-1:0]          outData;

  always #20 camClk = ~camClk;
  always #4  sysClk = ~sysClk;

  cam_line_mux #(.NUM_CH(NCH), .PIX_W(PW), .LINE_W(LW)) u0 (
    .camClk(camClk), .camRstN(camRstN), .lineValid(lineValid), .pixValid(pixValid),
    .pixData(pixData), .sysClk(sysClk), .sysRstN(sysRstN), .outValid(outValid),
    .outChan(outChan), .outPix(outPix), .outData(outData), .outLast(outLast),
    .overrun(overrun)
  );

  int checks = 0, errors = 0;
  int doneCount = 0, bursts = 0;
  bit monOn = 0, inBurst = 0, finished = 0;
  int curLine = 0, expCh = 0, expPx = 0;
  logic [PW-1:0] expData [NL][NCH][LW];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pixVal(int pat, int ln, int c, int p);
    case (pat)
      1:       return '1;
      2:       return PW'((ln << 12) | (c << 6) | p);
      default: return PW'($urandom);
    endcase
  endfunction

  // R2, R3: drive one line; only the first LW pixels enter the model
  task automatic sendLine(int npix, int idlePct, int blank, int pat);
    int ln = doneCount % NL;
    lineValid = 1;
    for (int p = 0; p < npix; p++) begin
      while (int'($urandom % 100) < idlePct) begin
        pixValid = 0;
        @(negedge camClk);
      end
      for (int c = 0; c < NCH; c++) begin
        logic [PW-1:0] v = pixVal(pat, ln, c, p);
        pixData[c*PW +: PW] = v;
        if (p < LW) expData[ln][c][p] = v;
      end
      pixValid = 1;
      @(negedge camClk);
    end
    pixValid  = 0;
    lineValid = 0;
    doneCount++;
    repeat (blank) @(negedge camClk);
  endtask

  always @(negedge sysClk) begin
    if (monOn) begin
      if (outValid) begin
        if (outChan == 0 && outPix == 0) begin
          if (inBurst) chk(overrun === 1'b1, "R9", "restart without overrun", overrun, 1);
          curLine = (doneCount - 1) % NL;
          inBurst = 1;
          expCh = 0;
          expPx = 0;
        end
        chk(inBurst && outChan == expCh && outPix == expPx, "R5", "beat order",
            {outChan, outPix}, (expCh << $clog2(LW)) | expPx);
        chk(outData === expData[curLine][outChan][outPix], "R6", "pixel data",
            outData, expData[curLine][outChan][outPix]);
        chk(outLast === (expPx == LW - 1), "R7", "last flag", outLast, expPx == LW - 1);
        if (expPx == LW - 1) begin
          expPx = 0;
          if (expCh == NCH - 1) begin
            inBurst = 0;
            bursts++;
          end else expCh++;
        end else expPx++;
      end else begin
        if (inBurst) chk(0, "R5", "gap in burst", 0, 1);
        if (outLast !== 1'b0) chk(0, "R8", "last while idle", outLast, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge sysClk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    #100;
    camRstN = 1;
    sysRstN = 1;
    @(negedge sysClk);
    chk(outValid === 1'b0, "R1", "outValid after reset", outValid, 0);
    chk(outLast === 1'b0, "R1", "outLast after reset", outLast, 0);
    chk(overrun === 1'b0, "R1", "overrun after reset", overrun, 0);
    monOn = 1;
    @(negedge camClk);

    sendLine(LW, 0, 90, 2);                 // R2 coded pattern, dense
    sendLine(LW, 0, 90, 1);                 // R2 all ones
    for (int i = 0; i < 6; i++)
      sendLine(LW, 30, 90, 0);              // R2, R4 random with pixel gaps
    sendLine(LW + 3, 10, 90, 0);            // R3 surplus pixels dropped
    chk(bursts == 9, "R4", "one readout per line", bursts, 9);
    chk(overrun === 1'b0, "R9", "no overrun on spaced lines", overrun, 0);
    chk(outValid === 1'b0, "R8", "idle after readouts", outValid, 0);

    sendLine(LW, 0, 1, 0);                  // R9 line A
    sendLine(LW, 0, 100, 0);                // R9 line B ends during A readout
    chk(overrun === 1'b1, "R9", "overrun raised", overrun, 1);
    chk(bursts == 10, "R9", "readout of newer line completes", bursts, 10);
    repeat (20) @(negedge sysClk);
    chk(overrun === 1'b1, "R9", "overrun sticky", overrun, 1);
    chk(!inBurst && outValid === 1'b0, "R8", "idle at end", outValid, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule